// File: doc/BRIEF.md
# DMA Bus Release Controller

This controller decides who owns a shared external bus: a DMA master, a refresh unit, or one of several internal bus masters. The DMA master has priority over the internal masters. Once it holds the bus, it keeps it until its transfer mode allows a hand-off. Each DMA transfer has a read half and a write half, and these two halves always stay together. No other owner or inserted cycle can come between them.

The DMA side reports its progress with single-cycle pulses: end of read, end of write, channel switch, end of the whole transfer, and end of a block. It also supplies its transfer mode and a give-up bit. The controller combines these into a release decision, flags that cycle on `ins_ok`, and then leaves the bus idle for one cycle. In the next cycle it grants the bus to the waiting requester with the highest priority. Every non-DMA owner holds its grant until it pulses its done line.

After a release the DMA master yields. Refresh is served first, then the internal master with the lowest index. The DMA master only gets the bus back when that owner has finished, or when nobody else was waiting.

Top module: `bus_release_ctrl`

## Requirements
- R1: Between an end-of-read pulse and the following end-of-write pulse, the bus stays with the DMA master and `ins_ok` stays 0, whatever the other requests, mode or give-up bit.
- R2: With `dma_mode` = 0 (cycle steal), the bus is released at every end-of-write. Value 3 is handled the same way.
- R3: With `dma_mode` = 1 (burst) and give-up clear, an end-of-write releases the bus only if `dma_xfer_end` is high in the same cycle.
- R4: With `dma_mode` = 2 (block) and give-up clear, an end-of-write releases the bus only if `dma_blk_end` is high in the same cycle.
- R5: An end-of-write that comes with `dma_chan_sw` high releases the bus in every mode.
- R6: With give-up set in burst or block mode, every end-of-write releases the bus, but never a point between read and write.
- R7: At most one grant is high at any time, and at least one cycle with no grant separates two owners.
- R8: After a DMA release, a pending refresh is granted before internal masters, and internal masters are served lowest index first. The DMA master gets the bus back only after that owner pulses done. If nobody else was waiting, it gets the bus back after the idle cycle.
- R9: On a free bus with no recent DMA release, the order is refresh, then DMA, then internal masters. An internal master is never granted over a requesting DMA master that has not just yielded.
- R10: If the DMA master drops its request, it releases the bus at once when outside a read/write pair. Inside a pair, it releases at the closing end-of-write.
- R11: While reset is applied, all grants and `ins_ok` are 0.
- R12: `ins_ok` is high exactly in the cycle in which the DMA release decision is taken, and `dma_gnt` falls at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | DMA master wants the bus |
| dma_mode | input | 2 | 0 cycle steal, 1 burst, 2 block, 3 as cycle steal |
| dma_give_up | input | 1 | Yield after each transfer unit in burst/block mode |
| dma_rd_done | input | 1 | Pulse: read half of a transfer finished |
| dma_wr_done | input | 1 | Pulse: write half finished (transfer unit complete) |
| dma_chan_sw | input | 1 | Qualifies end-of-write: next unit belongs to another channel |
| dma_xfer_end | input | 1 | Qualifies end-of-write: whole transfer complete |
| dma_blk_end | input | 1 | Qualifies end-of-write: block complete |
| rfsh_req | input | 1 | Refresh unit wants the bus |
| rfsh_done | input | 1 | Pulse: refresh cycle finished |
| int_req | input | N_INT | Internal master requests, bit 0 highest priority |
| int_done | input | N_INT | Internal master completion pulses |
| dma_gnt | output | 1 | Bus granted to DMA master |
| rfsh_gnt | output | 1 | Bus granted to refresh unit |
| int_gnt | output | N_INT | One-hot grant to an internal master |
| ins_ok | output | 1 | Legal point to insert another owner's cycles |

## Verification
The hardest case to reach is a release decision that depends on several things at once: the qualifier lines, the mode and the give-up bit, all at the closing end-of-write of a read/write pair that other masters are already waiting on. The bench resets the block and hands the bus to the DMA master with an internal request pending. It then opens a pair and holds it across an idle cycle. Finally it closes the pair with every combination of mode, give-up, channel switch, transfer end and block end, and compares `ins_ok` and the grant sequence with a release rule computed in the bench. Directed sequences then cover refresh precedence, yielding back, and a request dropped mid-pair.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    MODE_STEAL = 2'd0,
    MODE_BURST = 2'd1,
    MODE_BLOCK = 2'd2,
    MODE_RSVD  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_DMA  = 2'd1,
    OWN_RFSH = 2'd2,
    OWN_INT  = 2'd3
  } owner_e;
endpackage

// File: rtl/brc_release.sv
module brc_release
  import brc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dma_owner,
  input  logic       dma_req,
  input  xfer_mode_e mode,
  input  logic       give_up,
  input  logic       rd_done,
  input  logic       wr_done,
  input  logic       chan_sw,
  input  logic       xfer_end,
  input  logic       blk_end,
  output logic       in_pair,
  output logic       rel_now
);
  logic pair_q, pair_d;
  logic unit_rule;

  // Pair tracker: open on end of read, closed on end of write
  always_comb begin
    pair_d = pair_q;
    if (!dma_owner)   pair_d = 1'b0;
    else if (wr_done) pair_d = 1'b0;
    else if (rd_done) pair_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pair_q <= 1'b0;
    else        pair_q <= pair_d;
  end

  // Mode-dependent boundary rule at the close of a transfer unit
  always_comb begin
    unit_rule = chan_sw;
    unique case (mode)
      MODE_BURST: unit_rule = unit_rule | xfer_end | give_up;
      MODE_BLOCK: unit_rule = unit_rule | blk_end  | give_up;
      default:    unit_rule = 1'b1;
    endcase
  end

  always_comb begin
    rel_now = 1'b0;
    if (dma_owner) begin
      if (wr_done) rel_now = unit_rule | ~dma_req;
      else         rel_now = ~dma_req & ~pair_q & ~rd_done;
    end
  end

  assign in_pair = pair_q;

  assert_pair_owned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q |-> dma_owner);
  assert_no_split_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_q && !wr_done) |-> !rel_now);
endmodule

// File: rtl/brc_pick.sv
module brc_pick
  import brc_pkg::*;
#(
  parameter int N_INT = 3
) (
  input  logic             dma_req,
  input  logic             rf_req,
  input  logic [N_INT-1:0] int_req,
  input  logic             yield,
  output owner_e           pick,
  output logic [N_INT-1:0] pick_int
);
  localparam logic [N_INT-1:0] ONE = N_INT'(1);
  logic any_int;

  assign any_int  = |int_req;
  assign pick_int = int_req & (~int_req + ONE);

  always_comb begin
    if (rf_req)                             pick = OWN_RFSH;
    else if (dma_req && (!yield || !any_int)) pick = OWN_DMA;
    else if (any_int)                       pick = OWN_INT;
    else                                    pick = OWN_NONE;
  end
endmodule

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl
  import brc_pkg::*;
#(
  parameter int N_INT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_req,
  input  logic [1:0]       dma_mode,
  input  logic             dma_give_up,
  input  logic             dma_rd_done,
  input  logic             dma_wr_done,
  input  logic             dma_chan_sw,
  input  logic             dma_xfer_end,
  input  logic             dma_blk_end,
  input  logic             rfsh_req,
  input  logic             rfsh_done,
  input  logic [N_INT-1:0] int_req,
  input  logic [N_INT-1:0] int_done,
  output logic             dma_gnt,
  output logic             rfsh_gnt,
  output logic [N_INT-1:0] int_gnt,
  output logic             ins_ok
);
  owner_e           owner_q, owner_d, pick;
  logic [N_INT-1:0] sel_q, sel_d, pick_int;
  logic             yield_q, yield_d;
  logic             in_pair, rel_now;

  brc_release u_release (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_owner (owner_q == OWN_DMA),
    .dma_req   (dma_req),
    .mode      (xfer_mode_e'(dma_mode)),
    .give_up   (dma_give_up),
    .rd_done   (dma_rd_done),
    .wr_done   (dma_wr_done),
    .chan_sw   (dma_chan_sw),
    .xfer_end  (dma_xfer_end),
    .blk_end   (dma_blk_end),
    .in_pair   (in_pair),
    .rel_now   (rel_now)
  );

  brc_pick #(.N_INT(N_INT)) u_pick (
    .dma_req  (dma_req),
    .rf_req   (rfsh_req),
    .int_req  (int_req),
    .yield    (yield_q),
    .pick     (pick),
    .pick_int (pick_int)
  );

  // Next-state logic
  always_comb begin
    owner_d = owner_q;
    sel_d   = sel_q;
    yield_d = yield_q;
    unique case (owner_q)
      OWN_NONE: begin
        owner_d = pick;
        if (pick != OWN_NONE) yield_d = 1'b0;
        sel_d = (pick == OWN_INT) ? pick_int : '0;
      end
      OWN_DMA: if (rel_now) begin
        owner_d = OWN_NONE;
        yield_d = 1'b1;
      end
      OWN_RFSH: if (rfsh_done) owner_d = OWN_NONE;
      OWN_INT: if (|(int_done & sel_q)) begin
        owner_d = OWN_NONE;
        sel_d   = '0;
      end
      default: owner_d = OWN_NONE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      sel_q   <= '0;
      yield_q <= 1'b0;
    end else begin
      owner_q <= owner_d;
      sel_q   <= sel_d;
      yield_q <= yield_d;
    end
  end

  assign dma_gnt  = (owner_q == OWN_DMA);
  assign rfsh_gnt = (owner_q == OWN_RFSH);
  assign int_gnt  = (owner_q == OWN_INT) ? sel_q : '0;
  assign ins_ok   = rel_now;

  assert_atomic_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_pair |-> (!rfsh_gnt && int_gnt == '0));
  assert_steal_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && dma_wr_done && dma_mode == 2'd0) |=> !dma_gnt);
  assert_one_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_gnt, rfsh_gnt, int_gnt}));
  assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != OWN_NONE && owner_q != $past(owner_q)) |-> ($past(owner_q) == OWN_NONE));
  assert_int_below_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|int_gnt) |-> ($past(!dma_req) || $past(yield_q)));
  assert_release_point_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_gnt) |-> $past(ins_ok));
endmodule

// File: tb/test_bus_release_ctrl.sv
`timescale 1ns/1ps
module test_bus_release_ctrl;
  localparam int N = 3;
  logic clk = 1'b0;
  logic rst_n;
  logic dma_req, give_up, rd_done, wr_done, chan_sw, xfer_end, blk_end;
  logic [1:0] mode;
  logic rfsh_req, rfsh_done;
  logic [N-1:0] int_req, int_done;
  logic dma_gnt, rfsh_gnt, ins_ok;
  logic [N-1:0] int_gnt;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bus_release_ctrl #(.N_INT(N)) i_bus_release_ctrl (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_mode(mode),
    .dma_give_up(give_up), .dma_rd_done(rd_done), .dma_wr_done(wr_done),
    .dma_chan_sw(chan_sw), .dma_xfer_end(xfer_end), .dma_blk_end(blk_end),
    .rfsh_req(rfsh_req), .rfsh_done(rfsh_done), .int_req(int_req),
    .int_done(int_done), .dma_gnt(dma_gnt), .rfsh_gnt(rfsh_gnt),
    .int_gnt(int_gnt), .ins_ok(ins_ok));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_pulses();
    rd_done = 0; wr_done = 0; chan_sw = 0; xfer_end = 0; blk_end = 0;
    rfsh_done = 0; int_done = '0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    clear_pulses();
    tick();
    tick();
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dma_req = 0; mode = 0; give_up = 0; rfsh_req = 0; int_req = '0;
    clear_pulses();
    @(negedge clk);
    do_reset();
    rst_n = 0; #1;
    chk("R11", "grants in reset", {dma_gnt, rfsh_gnt, int_gnt, ins_ok}, 0);
    rst_n = 1;

    // Sweep of every mode / qualifier combination at a closing end-of-write
    for (int c = 0; c < 64; c++) begin
      logic [1:0] m;
      logic gu, cs, xe, be, rel;
      string tag;
      m = c[1:0]; gu = c[2]; cs = c[3]; xe = c[4]; be = c[5];
      rel = (m == 2'd0) || (m == 2'd3) || cs || (m == 2'd1 && (xe || gu)) ||
            (m == 2'd2 && (be || gu));
      if (cs) tag = "R5";
      else if (m == 2'd0 || m == 2'd3) tag = "R2";
      else if (gu) tag = "R6";
      else if (m == 2'd1) tag = "R3";
      else tag = "R4";
      dma_req = 1; int_req = 3'b001; rfsh_req = 0;
      do_reset();
      tick();
      chk("R9", "dma wins free bus", {dma_gnt, int_gnt}, 4'b1000);
      mode = m; give_up = gu; rd_done = 1; #1;
      chk("R1", "ins_ok at read end", ins_ok, 0);
      tick(); rd_done = 0; #1;
      chk("R1", "pair open, ins_ok", ins_ok, 0);
      tick();
      chk("R1", "dma keeps bus in pair", {dma_gnt, int_gnt}, 4'b1000);
      wr_done = 1; chan_sw = cs; xfer_end = xe; blk_end = be; #1;
      chk(tag, "ins_ok at write end", ins_ok, rel);
      chk("R12", "ins_ok at write end", ins_ok, rel);
      tick(); clear_pulses();
      chk(tag, "dma_gnt after write", dma_gnt, !rel);
      if (rel) begin
        chk("R7", "idle gap", {rfsh_gnt, int_gnt}, 0);
        tick();
        chk("R8", "internal master after release", {dma_gnt, int_gnt}, 4'b0001);
      end else begin
        tick();
        chk(tag, "bus still held", {dma_gnt, int_gnt}, 4'b1000);
      end
    end

    // Refresh precedence and return to DMA after completion
    mode = 0; give_up = 0; dma_req = 1; int_req = 3'b110; rfsh_req = 0;
    do_reset();
    tick();
    chk("R9", "dma over internal", dma_gnt, 1);
    rfsh_req = 1;
    tick();
    chk("R9", "refresh waits for release", {dma_gnt, rfsh_gnt}, 2'b10);
    wr_done = 1; #1;
    chk("R12", "steal release point", ins_ok, 1);
    tick(); clear_pulses();
    chk("R7", "gap before refresh", {dma_gnt, rfsh_gnt, int_gnt}, 0);
    tick();
    chk("R8", "refresh first", {dma_gnt, rfsh_gnt, int_gnt}, 5'b01000);
    tick(); tick();
    chk("R8", "refresh held until done", {dma_gnt, rfsh_gnt}, 2'b01);
    rfsh_req = 0; rfsh_done = 1;
    tick(); clear_pulses();
    chk("R7", "gap after refresh", {dma_gnt, rfsh_gnt, int_gnt}, 0);
    tick();
    chk("R8", "dma back after done", {dma_gnt, int_gnt}, 4'b1000);
    wr_done = 1;
    tick(); clear_pulses();
    tick();
    chk("R8", "lowest index internal", int_gnt, 3'b010);
    tick();
    chk("R8", "dma waits for done", {dma_gnt, int_gnt}, 4'b0010);
    int_done = 3'b010;
    tick(); clear_pulses();
    chk("R7", "gap after internal", {dma_gnt, int_gnt}, 0);
    tick();
    chk("R8", "dma back after internal", dma_gnt, 1);

    // Request dropped inside a pair, then outside
    mode = 1; int_req = 3'b100;
    rd_done = 1;
    tick(); clear_pulses();
    dma_req = 0; #1;
    chk("R10", "no release in pair", ins_ok, 0);
    tick();
    chk("R10", "held in pair", dma_gnt, 1);
    wr_done = 1; #1;
    chk("R10", "release at write end", ins_ok, 1);
    tick(); clear_pulses();
    tick();
    chk("R10", "internal after drop", {dma_gnt, int_gnt}, 4'b0100);
    int_done = 3'b100; int_req = 0; dma_req = 1;
    tick(); clear_pulses();
    tick();
    chk("R9", "dma on idle bus", dma_gnt, 1);
    dma_req = 0; #1;
    chk("R10", "drop outside pair", ins_ok, 1);
    tick();
    chk("R10", "bus freed", dma_gnt, 0);

    // Yield with no other requester: DMA regains after gap
    dma_req = 1; mode = 0;
    tick();
    chk("R8", "regrant", dma_gnt, 1);
    wr_done = 1;
    tick(); clear_pulses();
    chk("R7", "gap", dma_gnt, 0);
    tick();
    chk("R8", "dma regains alone", dma_gnt, 1);

    // Block mode with give-up: no release at read end
    mode = 2; give_up = 1; int_req = 3'b001;
    rd_done = 1; #1;
    chk("R6", "no release at read end", ins_ok, 0);
    tick(); clear_pulses();
    wr_done = 1; #1;
    chk("R6", "release at unit end", ins_ok, 1);
    tick(); clear_pulses();
    tick();
    chk("R6", "internal served", int_gnt, 3'b001);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule